// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This unit performs the add-class integer operations of a 32-bit RISC integer pipeline: register add, add of a sign-extended 16-bit immediate, reverse subtract (second operand minus first), add of the carry bit, one's complement plus carry, and two's complement negate. An accepted operation produces a registered result one clock later. The unit also keeps three flag registers: the carry bit, the overflow bit and a sticky summary-overflow bit. There is no subtract-immediate code. Software subtracts an immediate by adding its negated value.

The carry-in for the carry-consuming operations comes from the exception register on `ca_in`. The caller sets `ca_wr` for carrying variants, which writes the adder's carry-out into the carry flag. It sets `ovf_en` for variants that record overflow. When `ovf_en` is low, the overflow and summary-overflow flags are left untouched.

The summary-overflow bit is a two-state machine. In state `SO_IDLE` the bit reads 0. The transition `IDLE->LATCHED` is taken when an accepted operation with overflow recording enabled overflows. In state `SO_LATCHED` the bit reads 1. The transition `LATCHED->IDLE` is taken only on `so_clr`, and only when no new recorded overflow arrives in the same cycle.

Top module: `iadd_unit`

## Requirements
- R1: With `op`=0 the result is `opa + opb`. With `op`=1 the result is `opa` plus `imm` sign-extended from bit 15. Both results are modulo 2^32.
- R2: With `op`=2 the result is `opb - opa` modulo 2^32 (reverse order).
- R3: With `op`=3 the result is `opa + ca_in`. With `op`=4 it is `~opa + ca_in`. With `op`=5 it is `-opa`, so negating 0x80000000 returns 0x80000000.
- R4: An operation accepted on a clock edge (`in_valid`=1 and `op` in 0..5) sets `out_valid` to 1 and puts its result on `result` after that edge. After any other edge `out_valid` is 0 and `result` holds its value.
- R5: An accepted operation with `ca_wr`=1 loads `ca_flag` with the carry out of bit 31 of the 32-bit sum. For `op`=2 that carry is 1 exactly when `opb >= opa` unsigned. With `ca_wr`=0, `ca_flag` holds.
- R6: An accepted operation with `ovf_en`=1 loads `ov_flag` with 1 when the result overflows as a signed 32-bit value, and with 0 otherwise. With `ovf_en`=0, `ov_flag` holds.
- R7: `so_flag` becomes 1 after an accepted operation with `ovf_en`=1 that overflows. It stays 1 until a cycle with `so_clr`=1 clears it. If that clear cycle also brings a recorded overflow, the flag stays 1.
- R8: Operation codes 6 and 7, and cycles with `in_valid`=0, change neither `result`, `ca_flag` nor `ov_flag`.
- R9: After reset `result`, `out_valid`, `ca_flag`, `ov_flag` and `so_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0 add, 1 add-imm, 2 reverse-sub, 3 add-carry, 4 complement-plus-carry, 5 negate) |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate, sign-extended internally |
| ca_in | input | 1 | Carry-in from the exception register |
| ca_wr | input | 1 | Operation updates the carry flag |
| ovf_en | input | 1 | Operation records overflow |
| so_clr | input | 1 | Clear the sticky summary-overflow flag |
| result | output | 32 | Registered result |
| out_valid | output | 1 | Result was written on the last edge |
| ca_flag | output | 1 | Carry flag |
| ov_flag | output | 1 | Overflow flag |
| so_flag | output | 1 | Sticky summary-overflow flag |

## Verification
The hardest situation to reach from the ports is a single cycle in which a clear of the summary flag coincides with a new recorded overflow. Negation of the most negative value adds a second hard case, because exactly one operand value makes it overflow. The stimulus draws operands mostly from the sign and carry boundary values 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. It asserts `so_clr` often and independently of overflow. It also runs directed sequences that negate 0x80000000 and that clear the flag in the same cycle as an overflow. A behavioural model computes the operations in wide signed arithmetic and is compared on every clock.

// File: rtl/iadd_pkg.sv
package iadd_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 3'd0,
        OP_ADDI   = 3'd1,
        OP_SUBF   = 3'd2,
        OP_ADDZE  = 3'd3,
        OP_SUBFZE = 3'd4,
        OP_NEG    = 3'd5
    } op_e;

    typedef enum logic {
        SO_IDLE    = 1'b0,
        SO_LATCHED = 1'b1
    } so_state_e;

endpackage

// File: rtl/iadd_opsel.sv
module iadd_opsel
    import iadd_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [IW-1:0]   imm,
    input  logic            ca_in,
    output logic [W-1:0]    x,
    output logic [W-1:0]    y,
    output logic            cin,
    output logic            op_ok
);
    localparam int EXT = W - IW;

    logic [W-1:0] imm_ext;
    assign imm_ext = {{EXT{imm[IW-1]}}, imm};

    always_comb begin
        x     = a;
        y     = '0;
        cin   = 1'b0;
        op_ok = 1'b1;
        unique case (op)
            OP_ADD:    y = b;
            OP_ADDI:   y = imm_ext;
            OP_SUBF:   begin x = ~a; y = b; cin = 1'b1; end
            OP_ADDZE:  cin = ca_in;
            OP_SUBFZE: begin x = ~a; cin = ca_in; end
            OP_NEG:    begin x = ~a; cin = 1'b1; end
            default:   op_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/iadd_core.sv
module iadd_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign sum  = full[W-1:0];
    assign cout = full[W];
    assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/iadd_flags.sv
module iadd_flags
    import iadd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic ovf_en,
    input  logic ca_wr,
    input  logic cout,
    input  logic ovf,
    input  logic so_clr,
    output logic ca_q,
    output logic ov_q,
    output logic so_q
);
    so_state_e st, st_nx;
    logic      rec_ovf;

    assign rec_ovf = upd && ovf_en && ovf;

    always_comb begin
        st_nx = st;
        unique case (st)
            SO_IDLE:    if (rec_ovf) st_nx = SO_LATCHED;
            SO_LATCHED: if (so_clr && !rec_ovf) st_nx = SO_IDLE;
            default:    st_nx = SO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SO_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca_q <= 1'b0;
            ov_q <= 1'b0;
        end else begin
            if (upd && ca_wr)  ca_q <= cout;
            if (upd && ovf_en) ov_q <= ovf;
        end
    end

    assign so_q = (st == SO_LATCHED);

    // R7
    so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_q && !so_clr |=> so_q);
    // R7
    so_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd && ovf_en && ovf |=> so_q);
    // R7
    so_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_clr && !(upd && ovf_en && ovf) |=> !so_q);
    // R6
    ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd && ovf_en) |=> $stable(ov_q));
    // R5
    ca_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd && ca_wr) |=> $stable(ca_q));
endmodule

// File: rtl/iadd_unit.sv
module iadd_unit
    import iadd_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic [IW-1:0]   imm,
    input  logic            ca_in,
    input  logic            ca_wr,
    input  logic            ovf_en,
    input  logic            so_clr,
    output logic [W-1:0]    result,
    output logic            out_valid,
    output logic            ca_flag,
    output logic            ov_flag,
    output logic            so_flag
);
    logic [W-1:0] x, y, sum;
    logic         cin, op_ok, cout, ovf, upd;

    iadd_opsel #(.W(W), .IW(IW)) opsel_i (
        .op(op), .a(opa), .b(opb), .imm(imm), .ca_in(ca_in),
        .x(x), .y(y), .cin(cin), .op_ok(op_ok)
    );

    iadd_core #(.W(W)) core_i (
        .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
    );

    assign upd = in_valid && op_ok;

    iadd_flags flags_i (
        .clk(clk), .rst_n(rst_n), .upd(upd), .ovf_en(ovf_en), .ca_wr(ca_wr),
        .cout(cout), .ovf(ovf), .so_clr(so_clr),
        .ca_q(ca_flag), .ov_q(ov_flag), .so_q(so_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= upd;
            if (upd) result <= sum;
        end
    end

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_ok |=> out_valid);
    // R8
    reserved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && op_ok) |=> !out_valid && $stable(result));
    // R6
    ov_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (x[W-1] == y[W-1]));
endmodule

// File: tb/iadd_unit_tb_top.sv
`timescale 1ns/1ps
module iadd_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opa = '0, opb = '0;
    logic [15:0] imm = '0;
    logic        ca_in = 1'b0, ca_wr = 1'b0, ovf_en = 1'b0, so_clr = 1'b0;
    logic [31:0] result;
    logic        out_valid, ca_flag, ov_flag, so_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] e_res = '0;
    logic        e_v = 0, e_ca = 0, e_ov = 0, e_so = 0;
    string       res_tag = "R9";

    always #2 clk = ~clk;

    iadd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
        .imm(imm), .ca_in(ca_in), .ca_wr(ca_wr), .ovf_en(ovf_en), .so_clr(so_clr),
        .result(result), .out_valid(out_valid), .ca_flag(ca_flag),
        .ov_flag(ov_flag), .so_flag(so_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(res_tag, result, e_res);
        chk("R4 out_valid", {31'b0, out_valid}, {31'b0, e_v});
        chk("R5 ca_flag", {31'b0, ca_flag}, {31'b0, e_ca});
        chk("R6 ov_flag", {31'b0, ov_flag}, {31'b0, e_ov});
        chk("R7 so_flag", {31'b0, so_flag}, {31'b0, e_so});
    endtask

    // Drive one cycle at the negedge and advance the model to the state expected after the next posedge.
    task automatic step(input bit v, input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input bit ci, input bit cw, input bit oe, input bit clr);
        longint sa, sb, ua, ub, sv, uv, cl;
        bit ok, ovfl;
        in_valid = v; op = o; opa = a; opb = b; imm = im;
        ca_in = ci; ca_wr = cw; ovf_en = oe; so_clr = clr;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ua = longint'(a); ub = longint'(b); cl = longint'(ci);
        ok = 1; sv = 0; uv = 0;
        case (o)
            3'd0: begin sv = sa + sb; uv = ua + ub; res_tag = "R1 add"; end
            3'd1: begin sv = sa + longint'($signed(im)); uv = ua + longint'({{16{im[15]}}, im}); res_tag = "R1 addi"; end
            3'd2: begin sv = sb - sa; uv = ub + (64'd4294967295 - ua) + 1; res_tag = "R2 subf"; end
            3'd3: begin sv = sa + cl; uv = ua + cl; res_tag = "R3 addze"; end
            3'd4: begin sv = -sa - 1 + cl; uv = (64'd4294967295 - ua) + cl; res_tag = "R3 subfze"; end
            3'd5: begin sv = -sa; uv = (64'd4294967295 - ua) + 1; res_tag = "R3 neg"; end
            default: ok = 0;
        endcase
        ovfl = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        if (!(v && ok)) res_tag = "R8 ignored";
        e_v = v && ok;
        if (v && ok) begin
            e_res = uv[31:0];
            if (cw) e_ca = uv[32];
            if (oe) e_ov = ovfl;
        end
        if (v && ok && oe && ovfl) e_so = 1;
        else if (clr) e_so = 0;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 7)
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'h7FFFFFFF;
            3: return 32'h80000000;
            4: return 32'hFFFFFFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        res_tag = "R9 reset";
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        // R3: negate most negative value with overflow recording
        step(1, 3'd5, 32'h80000000, 0, 0, 0, 1, 1, 0);
        @(negedge clk); compare_all();
        // R7: clear coinciding with a new overflow keeps the flag set
        step(1, 3'd0, 32'h7FFFFFFF, 32'h1, 0, 0, 0, 1, 1);
        @(negedge clk); compare_all();
        // R6: overflow with recording off leaves flags; R7 clear alone
        step(1, 3'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, 1, 0, 1);
        @(negedge clk); compare_all();
        // R2/R5: reverse subtract with equal operands carries
        step(1, 3'd2, 32'h5, 32'h5, 0, 0, 1, 1, 0);
        @(negedge clk); compare_all();
        // R8: reserved code
        step(1, 3'd7, 32'h12345678, 32'h1, 0, 1, 1, 1, 0);
        @(negedge clk); compare_all();
        // R1: negative immediate
        step(1, 3'd1, 32'h10, 0, 16'hFFF0, 0, 1, 1, 0);
        @(negedge clk); compare_all();
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, 3'($urandom % 8), pick(), pick(), 16'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6) == 0);
            @(negedge clk);
            compare_all();
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule